// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous, multiplexed-address DRAM alive. After reset it holds off for a start-up pause. It then asks the access sequencer for the memory strobes and issues a burst of initial refresh cycles. When the burst is finished it raises `ready_o`, and from then on a free-running interval timer requests one refresh per interval. With the default timing, 2048 rows are covered every 32 ms, so one refresh is due about every 15.6 us.

Ownership of the strobes goes through a request/grant pair. The block raises `ref_req_o` while it has work. Once `ref_gnt_i` answers, it keeps the request high and drives RAS, CAS and WE itself until no work is left. The arbiter is expected to hold the grant for as long as the request stays high. If the grant is late, interval ticks are stored in a small saturating count and run back to back once the grant arrives.

A build parameter selects one of two refresh styles. The CAS-first style lets the memory's internal counter pick the row. The row-address style drives an internal row counter on the address lines and pulses only RAS. All durations are given in clock cycles.

Top module: `dram_ref_seq`

## Requirements
- R1: While reset is asserted and on release, RAS, CAS and WE are high (inactive), `ref_req_o` is low and `ready_o` is low.
- R2: `ref_req_o` stays low for the first PAUSE_CYC clock cycles after reset is released. It rises within a few cycles after that.
- R3: `ready_o` rises only after exactly INIT_REFRESHES refresh cycles have completed, with RAS high at that point. Once high, it stays high until reset.
- R4: RAS and CAS pulse only while `ref_req_o` is high and the grant has been given. No refresh starts while the grant is withheld. `ref_req_o` drops within a few cycles once no refresh is owed.
- R5: In CAS-first mode (MODE=REF_CBR), CAS is low for at least T_CSR cycles before RAS falls. CAS stays low for the whole RAS-low period. WE is held high at all times.
- R6: Every RAS-low pulse lasts at least T_RAS cycles. Between consecutive refreshes, RAS stays high for at least T_RP cycles.
- R7: After `ready_o`, with the grant always given, exactly one refresh starts per INTERVAL_CYC cycles.
- R8: Ticks that arrive while the grant is withheld are counted, with saturation at PEND_MAX. Once granted, exactly PEND_MAX refreshes run back to back.
- R9: In row-address mode (MODE=REF_RAS_ONLY), CAS stays high throughout. `addr_o` carries the row and is stable while RAS is low.
- R10: In row-address mode, the row on `addr_o` at each RAS fall is 0 for the first refresh after reset. It increases by one per refresh and wraps from 2^ROW_BITS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Grant of the strobes from the access sequencer |
| ref_req_o | output | 1 | Request for the strobes |
| ready_o | output | 1 | Start-up pause and initial refresh burst complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (always high) |
| addr_o | output | ROW_BITS | Row address in row-address mode, zero otherwise |

## Verification
The hardest state to reach from the ports is a saturated backlog: several interval ticks have to pile up while the request is already high but not yet granted. The bench gets there by withholding the grant just after a periodic refresh, for more than PEND_MAX intervals. It then releases the grant right after a tick, so that the next tick cannot fall inside the burst it counts. Row wrap is reached by building a second instance with a 4-bit row counter. That instance runs past sixteen refreshes while a scoreboard compares every row it drives.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_CAS_LEAD,
    ENG_RAS_LOW,
    ENG_PRECH
  } eng_state_e;

  typedef enum logic {
    REF_CBR      = 1'b0,
    REF_RAS_ONLY = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PAUSE_CYC    = 50000,
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pause_done_o,
  output logic tick_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] ival_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_cnt    <= '0;
      pause_done_o <= 1'b0;
    end else if (!pause_done_o) begin
      if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_done_o <= 1'b1;
      else pause_cnt <= pause_cnt + 1'b1;
    end
  end

  // interval timer only runs once initialisation is over
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ival_cnt <= '0;
      tick_o   <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (run_i) begin
        if (ival_cnt == IW'(INTERVAL_CYC - 1)) begin
          ival_cnt <= '0;
          tick_o   <= 1'b1;
        end else begin
          ival_cnt <= ival_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dram_ref_engine.sv
module dram_ref_engine
  import dram_ref_pkg::*;
#(
  parameter ref_mode_e MODE  = REF_CBR,
  parameter int        T_CSR = 2,
  parameter int        T_RAS = 15,
  parameter int        T_RP  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int T_MAX0 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int T_MAX  = (T_MAX0 > T_CSR) ? T_MAX0 : T_CSR;
  localparam int CW     = $clog2(T_MAX + 1);

  eng_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ENG_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (start_i) begin
          if (MODE == REF_CBR) begin
            state <= ENG_CAS_LEAD;
            cnt   <= CW'(T_CSR - 1);
          end else begin
            state <= ENG_RAS_LOW;
            cnt   <= CW'(T_RAS - 1);
          end
        end
        ENG_CAS_LEAD: if (cnt == '0) begin
          state <= ENG_RAS_LOW;
          cnt   <= CW'(T_RAS - 1);
        end else cnt <= cnt - 1'b1;
        ENG_RAS_LOW: if (cnt == '0) begin
          state <= ENG_PRECH;
          cnt   <= CW'(T_RP - 1);
        end else cnt <= cnt - 1'b1;
        ENG_PRECH: if (cnt == '0) state <= ENG_IDLE;
        else cnt <= cnt - 1'b1;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign idle_o  = (state == ENG_IDLE);
  assign done_o  = (state == ENG_PRECH) && (cnt == '0);
  assign ras_n_o = (state != ENG_RAS_LOW);
  // CAS is held across the whole RAS-low phase in CAS-first mode
  assign cas_n_o = !((MODE == REF_CBR) &&
                     ((state == ENG_CAS_LEAD) || (state == ENG_RAS_LOW)));
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter ref_mode_e MODE           = REF_CBR,
  parameter int        ROW_BITS       = 11,
  parameter int        PAUSE_CYC      = 50000,
  parameter int        INTERVAL_CYC   = 3900,
  parameter int        INIT_REFRESHES = 8,
  parameter int        PEND_MAX       = 4,
  parameter int        T_CSR          = 2,
  parameter int        T_RAS          = 15,
  parameter int        T_RP           = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_gnt_i,
  output logic                ref_req_o,
  output logic                ready_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [ROW_BITS-1:0] addr_o
);
  localparam int PDW = $clog2(PEND_MAX + 1);
  localparam int IDW = $clog2(INIT_REFRESHES + 1);

  logic           pause_done, tick, eng_idle, eng_done, start, need, own;
  logic [PDW-1:0] pend;
  logic [IDW-1:0] init_left;

  dram_ref_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ready_o),
    .pause_done_o(pause_done),
    .tick_o      (tick)
  );

  dram_ref_engine #(
    .MODE (MODE),
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .idle_o (eng_idle),
    .done_o (eng_done),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
  );

  assign ready_o   = pause_done && (init_left == '0);
  assign need      = ready_o ? (pend != '0) : (pause_done && (init_left != '0));
  assign ref_req_o = need || own;
  assign start     = own && eng_idle && need;
  assign we_n_o    = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_left <= IDW'(INIT_REFRESHES);
    else if (eng_done && !ready_o) init_left <= init_left - 1'b1;
  end

  // saturating backlog of interval ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= '0;
    else begin
      unique case ({tick, eng_done && ready_o})
        2'b10:   if (pend != PDW'(PEND_MAX)) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own <= 1'b0;
    else if (!own) own <= need && ref_gnt_i;
    else if (eng_idle && !need) own <= 1'b0;
  end

  generate
    if (MODE == REF_RAS_ONLY) begin : g_row
      logic [ROW_BITS-1:0] row;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row <= '0;
        else if (eng_done) row <= row + 1'b1;
      end
      assign addr_o = row;
    end else begin : g_norow
      assign addr_o = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_ref_seq_chk.sv
module dram_ref_seq_chk
  import dram_ref_pkg::*;
#(
  parameter ref_mode_e MODE     = REF_CBR,
  parameter int        ROW_BITS = 11,
  parameter int        T_CSR    = 2,
  parameter int        T_RAS    = 15,
  parameter int        T_RP     = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ref_gnt_i,
  input logic                ref_req_o,
  input logic                ready_o,
  input logic                ras_n_o,
  input logic                cas_n_o,
  input logic                we_n_o,
  input logic [ROW_BITS-1:0] addr_o
);
  logic        ras_q;
  logic [15:0] low_len, high_len, cas_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q    <= 1'b1;
      low_len  <= '0;
      high_len <= 16'hffff;
      cas_len  <= '0;
    end else begin
      ras_q <= ras_n_o;
      if (!ras_n_o) low_len <= (ras_q ? 16'd1 : (low_len == 16'hffff ? low_len : low_len + 1'b1));
      if (ras_n_o) high_len <= (!ras_q ? 16'd1 : (high_len == 16'hffff ? high_len : high_len + 1'b1));
      if (!cas_n_o) cas_len <= (cas_len == 16'hffff) ? cas_len : cas_len + 1'b1;
      else cas_len <= '0;
    end
  end

  // R4
  strobe_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_req_o |-> ras_n_o && cas_n_o);
  // R4
  strobe_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> ref_gnt_i);
  // R3
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R5
  we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) we_n_o);
  // R6
  ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_o && !ras_q |-> low_len >= 16'(T_RAS));
  // R6
  precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o && ras_q |-> high_len >= 16'(T_RP));
  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o && !ras_q |-> $stable(addr_o));

  generate
    if (MODE == REF_CBR) begin : g_cbr
      // R5
      cas_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o && ras_q |-> cas_len >= 16'(T_CSR));
      // R5
      cas_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o |-> !cas_n_o);
    end else begin : g_ro
      logic [ROW_BITS-1:0] last_row;
      logic                seen;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          last_row <= '0;
          seen     <= 1'b0;
        end else if (!ras_n_o && ras_q) begin
          last_row <= addr_o;
          seen     <= 1'b1;
        end
      end
      // R9
      cas_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cas_n_o);
      // R10
      row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o && ras_q && seen |-> addr_o == last_row + 1'b1);
    end
  endgenerate
endmodule

bind dram_ref_seq dram_ref_seq_chk #(
  .MODE    (MODE),
  .ROW_BITS(ROW_BITS),
  .T_CSR   (T_CSR),
  .T_RAS   (T_RAS),
  .T_RP    (T_RP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_gnt_i(ref_gnt_i),
  .ref_req_o(ref_req_o),
  .ready_o  (ready_o),
  .ras_n_o  (ras_n_o),
  .cas_n_o  (cas_n_o),
  .we_n_o   (we_n_o),
  .addr_o   (addr_o)
);

// File: tb/dram_ref_seq_tb.sv
module dram_ref_seq_tb;
  import dram_ref_pkg::*;

  localparam int PAUSE = 200;
  localparam int IVAL  = 150;
  localparam int INIT  = 8;
  localparam int PMAX  = 4;
  localparam int TCSR  = 2;
  localparam int TRAS  = 15;
  localparam int TRP   = 10;
  localparam int RB    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_en = 1'b0;
  always #2 clk = ~clk;

  logic c_req, c_rdy, c_ras, c_cas, c_we, c_gnt;
  logic [10:0] c_addr;
  logic r_req, r_rdy, r_ras, r_cas, r_we, r_gnt;
  logic [RB-1:0] r_addr;

  assign c_gnt = c_req && gnt_en;
  assign r_gnt = r_req && gnt_en;

  dram_ref_seq #(
    .MODE(REF_CBR), .ROW_BITS(11), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVAL),
    .INIT_REFRESHES(INIT), .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(c_gnt), .ref_req_o(c_req),
    .ready_o(c_rdy), .ras_n_o(c_ras), .cas_n_o(c_cas), .we_n_o(c_we), .addr_o(c_addr)
  );

  dram_ref_seq #(
    .MODE(REF_RAS_ONLY), .ROW_BITS(RB), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVAL),
    .INIT_REFRESHES(INIT), .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut_ro (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(r_gnt), .ref_req_o(r_req),
    .ready_o(r_rdy), .ras_n_o(r_ras), .cas_n_o(r_cas), .we_n_o(r_we), .addr_o(r_addr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard of expected rows for the row-address instance
  int exp_rows[$];
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_rows.push_back(i % (1 << RB));
  endtask

  // monitor: CAS-first instance
  int c_falls = 0;
  int c_lo = 0, c_hi = 0, c_caslo = 0;
  bit c_ras_p = 1'b1, c_rdy_p = 1'b0, c_broke = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!c_ras && c_ras_p) begin
      check(!c_cas && c_caslo >= TCSR, "R5 cas lead", c_caslo, TCSR);
      if (c_falls > 0) check(c_hi >= TRP, "R6 precharge", c_hi, TRP);
      check(c_we, "R5 we high", c_we, 1);
      c_falls++;
      c_lo = 0;
      c_broke = 1'b0;
    end
    if (c_ras && !c_ras_p) begin
      check(c_lo >= TRAS, "R6 ras width", c_lo, TRAS);
      check(!c_broke, "R5 cas hold", c_broke, 0);
      c_hi = 0;
    end
    if (!c_ras) begin
      c_lo++;
      if (c_cas) c_broke = 1'b1;
    end else c_hi++;
    c_caslo = c_cas ? 0 : c_caslo + 1;
    if (c_rdy && !c_rdy_p) begin
      check(c_falls == INIT, "R3 init count", c_falls, INIT);
      check(c_ras, "R3 ras idle at ready", c_ras, 1);
    end
    if (c_rdy_p && !c_rdy) check(1'b0, "R3 ready dropped", 0, 1);
    c_ras_p = c_ras;
    c_rdy_p = c_rdy;
  end

  // monitor: row-address instance
  int r_falls = 0;
  logic [RB-1:0] r_hold;
  bit r_ras_p = 1'b1, r_rdy_p = 1'b0, r_casbad = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!r_cas) r_casbad = 1'b1;
    if (!r_ras && r_ras_p) begin
      if (exp_rows.size() == 0) check(1'b0, "R10 unexpected refresh", r_addr, -1);
      else begin
        int e;
        e = exp_rows.pop_front();
        check(int'(r_addr) == e, "R10 row", r_addr, e);
      end
      r_hold = r_addr;
      r_falls++;
    end
    if (r_ras && !r_ras_p) check(r_hold == r_addr, "R9 addr stable", r_addr, r_hold);
    if (r_rdy && !r_rdy_p) check(r_falls == INIT, "R3 init count ro", r_falls, INIT);
    r_ras_p = r_ras;
    r_rdy_p = r_rdy;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    push_rows(64);
    repeat (3) @(negedge clk);
    // R1
    check(c_ras && c_cas && c_we && !c_req && !c_rdy, "R1 reset idle",
          {c_ras, c_cas, c_we, c_req, c_rdy}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check(c_ras && c_cas && !c_req && !c_rdy, "R1 after release",
          {c_ras, c_cas, c_req, c_rdy}, 4'b1100);
    repeat (PAUSE - 6) @(negedge clk);
    check(!c_req && !r_req, "R2 quiet pause", c_req, 0);
    repeat (10) @(negedge clk);
    check(c_req && r_req, "R2 request after pause", c_req, 1);
    check(!c_rdy, "R3 not ready before refresh", c_rdy, 0);
    repeat (40) @(negedge clk);
    check(c_falls == 0 && r_falls == 0, "R4 no refresh without grant", c_falls, 0);
    gnt_en = 1'b1;
    while (!c_rdy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(!c_req, "R4 request dropped", c_req, 0);
    f0 = c_falls;
    repeat (520) @(negedge clk);
    check(c_falls - f0 == 3, "R7 periodic", c_falls - f0, 3);
    gnt_en = 1'b0;
    f0 = c_falls;
    repeat (1135) @(negedge clk);
    check(c_falls == f0, "R4 withheld grant", c_falls - f0, 0);
    check(c_req, "R8 request held", c_req, 1);
    gnt_en = 1'b1;
    repeat (125) @(negedge clk);
    check(c_falls - f0 == PMAX, "R8 saturated backlog", c_falls - f0, PMAX);
    repeat (1300) @(negedge clk);
    check(r_falls > (1 << RB), "R10 wrap reached", r_falls, (1 << RB) + 1);
    check(!r_casbad, "R9 cas idle", r_casbad, 0);
    check(c_rdy && r_rdy, "R3 ready held", c_rdy, 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule